// File: doc/BRIEF.md
# Nibble-Serial Multiword Add/Subtract Unit

This block adds or subtracts two two's-complement operands that are several nibbles wide. It reuses a single 4-bit adder once per clock, starting with the least significant nibble. A register carries each step's carry out into the next nibble. A subtract is done as A plus the bitwise inverse of B, with the carry-in of the lowest nibble forced to one, so no separate incrementer is needed.

The caller drives both operands, the operation select and the carry-polarity mode, then pulses `start`. The `done` pulse arrives after exactly `NIBBLES` clock edges. The full-width result and the carry, overflow, sign and zero flags then hold until the next accepted start.

In borrow mode a subtract reports an inverted carry, so a 1 means a borrow happened. The carry chain is kept in that same inverted form from step to step. An add reports the raw carry in either mode.

Top module: `nsa_serial_addsub`

## Requirements
- R1: With `op_sub`=0 the `result` equals (A + B) mod 2^(4·NIBBLES), computed with a lowest-nibble carry-in of 0.
- R2: With `op_sub`=1 the `result` equals (A − B) mod 2^(4·NIBBLES), computed as A + ~B + 1. The carry out of the top bit is dropped from the result.
- R3: With `borrow_mode`=0, `flag_c` is the carry out of the top bit of the whole operation. For a subtract, 1 means no borrow (A ≥ B unsigned).
- R4: With `borrow_mode`=1, a subtract reports `flag_c`=1 exactly when A < B unsigned, and the carry chain is held inverted between steps. An add still reports the raw carry.
- R5: `flag_v` is the XOR of the carry into and the carry out of the overall top bit. Operands whose effective top bits differ never produce `flag_v`=1.
- R6: `flag_n` equals the top bit of `result`. `flag_z` is 1 only when every result nibble is zero.
- R7: `done` is high for exactly one cycle, `NIBBLES` clock edges after the edge that accepts `start`.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. It does not change the running operation's result, flags or timing.
- R9: `result` and all flags hold their values from `done` until the next accepted `start`, whatever the operand inputs do.
- R10: A synchronous reset clears `result`, all flags, `done` and the step sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| borrow_mode | input | 1 | 0 = raw carry, 1 = inverted borrow on subtract |
| a_in | input | 4·NIBBLES | First operand |
| b_in | input | 4·NIBBLES | Second operand |
| result | output | 4·NIBBLES | Full-width result |
| done | output | 1 | One-cycle completion pulse |
| flag_c | output | 1 | Carry, or borrow in borrow mode |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Sign of result |
| flag_z | output | 1 | Result is zero |

## Verification
Several rules are checked on every clock:
- `done` lasts one cycle and arrives after the right number of edges.
- A busy sequencer keeps stepping through a start pulse.
- The flags stay still while idle.
- `flag_n` and `flag_z` agree with the final `result`.
- A nibble whose operands differ in sign never produces overflow.

The arithmetic itself can only be shown by the bench scenarios, which compare against a full-width reference. These include the carry and borrow polarities, the overflow on maximum-positive plus one and most-negative minus one, the zero result of equal-operand subtracts, and the effect of a mid-run reset.

// File: rtl/nsa_pkg.sv
package nsa_pkg;
   localparam int NIB_W = 4;

   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } nsa_flags_t;

   function automatic int cnt_width(input int steps);
      return (steps > 1) ? $clog2(steps) : 1;
   endfunction
endpackage

// File: rtl/nsa_nibble_adder.sv
module nsa_nibble_adder
   import nsa_pkg::*;
#(
   parameter int STYLE = 0   // 0 = explicit ripple cells, 1 = behavioural sums
) (
   input  logic [NIB_W-1:0] a,
   input  logic [NIB_W-1:0] b,
   input  logic             cin,
   output logic [NIB_W-1:0] sum,
   output logic             cout,
   output logic             c_msb   // carry into bit NIB_W-1
);
   generate
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("nsa_nibble_adder: STYLE must be 0 or 1");
      end
      if (STYLE == 0) begin : g_ripple
         logic [NIB_W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < NIB_W; i++) begin : g_cell
            assign sum[i]  = a[i] ^ b[i] ^ c[i];
            assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout  = c[NIB_W];
         assign c_msb = c[NIB_W-1];
      end else begin : g_behav
         logic [NIB_W:0]   full;
         logic [NIB_W-1:0] low;
         assign full  = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
         assign low   = {1'b0, a[NIB_W-2:0]} + {1'b0, b[NIB_W-2:0]}
                        + {{(NIB_W-1){1'b0}}, cin};
         assign sum   = full[NIB_W-1:0];
         assign cout  = full[NIB_W];
         assign c_msb = low[NIB_W-1];
      end
   endgenerate

   // R5: operands of differing sign cannot overflow
   always_comb begin
      if (a[NIB_W-1] != b[NIB_W-1]) begin
         a_r5_mixed_sign_no_overflow: assert (c_msb == cout);
      end
   end
endmodule

// File: rtl/nsa_sequencer.sv
module nsa_sequencer
   import nsa_pkg::*;
#(
   parameter int NIBBLES = 4,
   localparam int CNT_W  = cnt_width(NIBBLES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             accept,
   output logic             busy,
   output logic             last,
   output logic [CNT_W-1:0] step,
   output logic             done
);
   logic             busy_q, done_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept = start & ~busy_q;
   assign last   = busy_q & (cnt_q == CNT_W'(NIBBLES - 1));
   assign busy   = busy_q;
   assign step   = cnt_q;
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R7: done pulse lasts a single cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

   // R8: a busy sequencer keeps stepping whatever start does
   a_r8_busy_keeps_stepping: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !last) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/nsa_flag_unit.sv
module nsa_flag_unit
   import nsa_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             op_sub,
   input  logic             borrow_mode,
   input  logic             busy,
   input  logic             last,
   input  logic [NIB_W-1:0] sum,
   input  logic             cout,
   input  logic             c_msb,
   output logic             invert_b,
   output logic             cin,
   output nsa_flags_t       flags
);
   logic       sub_q, bm_q, cy_q, zacc_q;
   logic       flip;
   logic       cy_next;
   logic       nib_zero;
   nsa_flags_t flags_q;

   assign flip     = sub_q & bm_q;
   assign cin      = flip ? ~cy_q : cy_q;
   assign cy_next  = flip ? ~cout : cout;
   assign nib_zero = (sum == '0);
   assign invert_b = sub_q;
   assign flags    = flags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sub_q   <= 1'b0;
         bm_q    <= 1'b0;
         cy_q    <= 1'b0;
         zacc_q  <= 1'b0;
         flags_q <= '0;
      end else if (accept) begin
         sub_q   <= op_sub;
         bm_q    <= borrow_mode;
         // stored in reported polarity: raw 1 for subtract, borrow 0 in borrow mode
         cy_q    <= op_sub & ~borrow_mode;
         zacc_q  <= 1'b1;
         flags_q <= '0;
      end else if (busy) begin
         cy_q   <= cy_next;
         zacc_q <= zacc_q & nib_zero;
         if (last) begin
            flags_q.c <= cy_next;
            flags_q.v <= cout ^ c_msb;
            flags_q.n <= sum[NIB_W-1];
            flags_q.z <= zacc_q & nib_zero;
         end
      end
   end

   // R9: flags frozen while idle and no start accepted
   a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
      (!busy && !accept) |=> $stable(flags_q));
endmodule

// File: rtl/nsa_serial_addsub.sv
module nsa_serial_addsub
   import nsa_pkg::*;
#(
   parameter int NIBBLES     = 4,
   parameter int ADDER_STYLE = 0,
   localparam int W          = NIBBLES * NIB_W,
   localparam int CNT_W      = cnt_width(NIBBLES)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         op_sub,
   input  logic         borrow_mode,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] result,
   output logic         done,
   output logic         flag_c,
   output logic         flag_v,
   output logic         flag_n,
   output logic         flag_z
);
   generate
      if (NIBBLES < 1) begin : g_bad_nibbles
         $error("nsa_serial_addsub: NIBBLES must be at least 1");
      end
   endgenerate

   logic             accept, busy, last, invert_b, cin;
   logic [CNT_W-1:0] step;
   logic [W-1:0]     a_q, b_q, res_q;
   logic [NIB_W-1:0] a_nib, b_nib, sum;
   logic             cout, c_msb;
   nsa_flags_t       flags;

   nsa_sequencer #(.NIBBLES(NIBBLES)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .accept (accept),
      .busy   (busy),
      .last   (last),
      .step   (step),
      .done   (done)
   );

   assign a_nib = a_q[int'(step) * NIB_W +: NIB_W];
   assign b_nib = b_q[int'(step) * NIB_W +: NIB_W] ^ {NIB_W{invert_b}};

   nsa_nibble_adder #(.STYLE(ADDER_STYLE)) u_add (
      .a     (a_nib),
      .b     (b_nib),
      .cin   (cin),
      .sum   (sum),
      .cout  (cout),
      .c_msb (c_msb)
   );

   nsa_flag_unit u_flags (
      .clk         (clk),
      .rst         (rst),
      .accept      (accept),
      .op_sub      (op_sub),
      .borrow_mode (borrow_mode),
      .busy        (busy),
      .last        (last),
      .sum         (sum),
      .cout        (cout),
      .c_msb       (c_msb),
      .invert_b    (invert_b),
      .cin         (cin),
      .flags       (flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
      end else if (accept) begin
         a_q   <= a_in;
         b_q   <= b_in;
         res_q <= '0;
      end else if (busy) begin
         res_q[int'(step) * NIB_W +: NIB_W] <= sum;
      end
   end

   assign result = res_q;
   assign flag_c = flags.c;
   assign flag_v = flags.v;
   assign flag_n = flags.n;
   assign flag_z = flags.z;

   // edge counter used only by the latency check
   logic [CNT_W:0] since_q;
   always_ff @(posedge clk) begin
      if (rst)         since_q <= '0;
      else if (accept) since_q <= '0;
      else if (busy)   since_q <= since_q + 1'b1;
   end

   // R7: done arrives NIBBLES edges after acceptance
   a_r7_latency: assert property (@(posedge clk) disable iff (rst)
      done |-> (since_q == (CNT_W+1)'(NIBBLES)));

   // R6: sign and zero flags agree with the final result
   a_r6_sign_matches: assert property (@(posedge clk) disable iff (rst)
      done |-> (flag_n == result[W-1]));
   a_r6_zero_matches: assert property (@(posedge clk) disable iff (rst)
      done |-> (flag_z == (result == '0)));

   // R9: result frozen while idle
   a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
      (!busy && !accept) |=> $stable(res_q));
endmodule

// File: tb/sim_nsa_serial_addsub.sv
module sim_nsa_serial_addsub;
   localparam int N = 4;
   localparam int W = N * 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         op_sub = 1'b0;
   logic         borrow_mode = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] result;
   logic         done, flag_c, flag_v, flag_n, flag_z;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   nsa_serial_addsub #(.NIBBLES(N)) u0 (
      .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
      .borrow_mode(borrow_mode), .a_in(a_in), .b_in(b_in),
      .result(result), .done(done), .flag_c(flag_c), .flag_v(flag_v),
      .flag_n(flag_n), .flag_z(flag_z)
   );

   // {sub, borrow_mode, a, b}
   localparam logic [33:0] VEC [10] = '{
      {1'b0, 1'b0, 16'h1234, 16'h4321},
      {1'b0, 1'b0, 16'hFFFF, 16'h0001},
      {1'b0, 1'b1, 16'hF00F, 16'h0FF1},
      {1'b1, 1'b0, 16'h00AD, 16'h0001},
      {1'b1, 1'b1, 16'h0001, 16'h0002},
      {1'b1, 1'b0, 16'h0001, 16'h0002},
      {1'b0, 1'b0, 16'h0004, 16'hFFFD},
      {1'b0, 1'b0, 16'h8000, 16'h8000},
      {1'b1, 1'b1, 16'hA5A5, 16'h5A5A},
      {1'b0, 1'b1, 16'h0F0F, 16'h00F1}
   };

   logic [W-1:0] e_res;
   logic         e_c, e_v, e_n, e_z;

   task automatic ref_model(input logic s, input logic bm,
                            input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] bx;
      logic [W:0]   full;
      logic [W-1:0] low;
      bx    = s ? ~b : b;
      full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, s};
      low   = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, s};
      e_res = full[W-1:0];
      e_c   = (s && bm) ? ~full[W] : full[W];
      e_v   = full[W] ^ low[W-1];
      e_n   = e_res[W-1];
      e_z   = (e_res == '0);
   endtask

   task automatic chk(input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R1/R2 result"}, result, e_res);
      chk({tag, " R3/R4 carry"}, W'(flag_c), W'(e_c));
      chk({tag, " R5 overflow"}, W'(flag_v), W'(e_v));
      chk({tag, " R6 sign"}, W'(flag_n), W'(e_n));
      chk({tag, " R6 zero"}, W'(flag_z), W'(e_z));
   endtask

   // drives one operation; returns edges from acceptance to done
   task automatic run_op(input logic s, input logic bm,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         output int cyc);
      @(negedge clk);
      op_sub = s; borrow_mode = bm; a_in = a; b_in = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int cyc;
      logic [W-1:0] keep_res;

      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 reset result", result, '0);
      chk("R10 reset done", W'(done), '0);
      chk("R10 reset flags", W'({flag_c, flag_v, flag_n, flag_z}), '0);
      rst = 1'b0;

      // vector table: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < 10; i++) begin
         ref_model(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
         run_op(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], cyc);
         chk("R7 latency", W'(cyc), W'(N));
         check_all("table");
         @(negedge clk);
         chk("R7 done one cycle", W'(done), '0);
      end

      // random operands against full-width reference
      for (int i = 0; i < 60; i++) begin
         logic s, bm;
         logic [W-1:0] a, b;
         s = 1'($urandom); bm = 1'($urandom);
         a = W'($urandom); b = W'($urandom);
         ref_model(s, bm, a, b);
         run_op(s, bm, a, b, cyc);
         check_all("random");
      end

      // R5 corner: max positive plus one
      ref_model(1'b0, 1'b0, 16'h7FFF, 16'h0001);
      run_op(1'b0, 1'b0, 16'h7FFF, 16'h0001, cyc);
      check_all("maxpos+1");
      chk("R5 maxpos+1 overflow set", W'(flag_v), W'(1));

      // R5 corner: most negative minus one
      ref_model(1'b1, 1'b0, 16'h8000, 16'h0001);
      run_op(1'b1, 1'b0, 16'h8000, 16'h0001, cyc);
      check_all("minneg-1");
      chk("R5 minneg-1 overflow set", W'(flag_v), W'(1));

      // R3 equal operands subtract: zero, carry 1 (no borrow)
      ref_model(1'b1, 1'b0, 16'h3C3C, 16'h3C3C);
      run_op(1'b1, 1'b0, 16'h3C3C, 16'h3C3C, cyc);
      chk("R6 equal sub zero", W'(flag_z), W'(1));
      chk("R3 equal sub raw carry", W'(flag_c), W'(1));
      // R4 same in borrow mode: no borrow
      run_op(1'b1, 1'b1, 16'h3C3C, 16'h3C3C, cyc);
      chk("R4 equal sub borrow clear", W'(flag_c), W'(0));
      run_op(1'b1, 1'b1, 16'h0000, 16'h0001, cyc);
      chk("R4 borrow set when a<b", W'(flag_c), W'(1));
      chk("R2 0-1 result", result, 16'hFFFF);

      // R9: hold after done while inputs move
      ref_model(1'b0, 1'b0, 16'h1111, 16'h2222);
      run_op(1'b0, 1'b0, 16'h1111, 16'h2222, cyc);
      a_in = 16'hDEAD; b_in = 16'hBEEF; op_sub = 1'b1; borrow_mode = 1'b1;
      repeat (6) @(negedge clk);
      check_all("R9 hold");

      // R8: start while busy is ignored
      ref_model(1'b0, 1'b0, 16'h0F0F, 16'h0101);
      @(negedge clk);
      op_sub = 1'b0; borrow_mode = 1'b0; a_in = 16'h0F0F; b_in = 16'h0101;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      a_in = 16'hFFFF; b_in = 16'hFFFF; op_sub = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk("R8 busy start timing", W'(cyc), W'(N));
      check_all("R8 busy start");
      repeat (3) @(negedge clk);
      chk("R8 no second done", W'(done), '0);
      chk("R8 result kept", result, e_res);

      // R10: reset mid-operation
      @(negedge clk);
      op_sub = 1'b0; a_in = 16'hFFFF; b_in = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R10 mid reset result", result, '0);
      chk("R10 mid reset flags", W'({flag_c, flag_v, flag_n, flag_z}), '0);
      keep_res = result;
      repeat (N + 2) @(negedge clk);
      chk("R10 no done after reset", W'(done), '0);
      chk("R10 result stays clear", result, keep_res);

      ref_model(1'b1, 1'b0, 16'h00AD, 16'h0001);
      run_op(1'b1, 1'b0, 16'h00AD, 16'h0001, cyc);
      check_all("after reset");
      chk("R7 latency after reset", W'(cyc), W'(N));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule